// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by walking a radix page table held in memory. A request gives the virtual address, the kind of access (instruction fetch, load or store), the current privilege, the machine-mode override bits, the root page number, the translation mode and the SUM and MXR permission modifiers. The walker fetches one page-table entry per level over a simple memory port, checks the leaf it finds against every legality rule, and returns a physical address with read, write and execute permissions or a fault.

Three modes are supported: a bare pass-through, a two-level scheme with 4-byte entries and 10 index bits per level, and a three-level scheme with 8-byte entries and 9 index bits per level. Pages are 4 KiB. When a successful leaf lacks its accessed bit, or lacks its dirty bit on a store, the walker issues a compare-and-swap write. The memory answers with the value it held. If that value differs from the entry that was read, some other agent changed the table, and the walk starts again from the root.

Top module: `pt_walker`

## Requirements
- R1: When the effective privilege is machine (code 3) or the mode is bare (mode code 0), the request completes with no memory traffic: the physical address equals the low PA_W bits of the virtual address and read, write and execute are all granted.
- R2: For a load (access code 1) or a store (access code 2) issued in machine mode with the override flag set, the effective privilege is taken from the override privilege input. A fetch (access code 0) ignores the override.
- R3: In the three-level mode (mode code 2), virtual address bits 63:39 must all equal bit 38, otherwise the access faults without reading memory. In the two-level mode (mode code 1) only bits 31:0 of the virtual address are used. Mode code 3 always faults.
- R4: The walk starts at the top level with base = root × 4096. The entry address is base + index × entry size, using 8-byte entries and index bits {38:30, 29:21, 20:12} in mode 2, and 4-byte entries and index bits {31:22, 21:12} in mode 1. Entry flag bits are V=0, R=1, W=2, X=3, U=4, A=6 and D=7. The PPN sits at bits 53:10 in mode 2 and at bits 31:10 in mode 1.
- R5: An entry with V clear faults. An entry with R, W and X all clear is a pointer whose PPN × 4096 becomes the next base, and a pointer at the last level faults. A faulting access reports address 0 and no permissions.
- R6: A leaf with W set and R clear (W-only or W+X) is reserved and faults.
- R7: A leaf with U set faults from a privilege other than user (code 0) unless SUM is set. It always faults for a fetch from a privilege other than user. A leaf with U clear faults from any privilege other than supervisor (code 1).
- R8: A leaf above the last level is a superpage. Its PPN bits that cover the remaining levels must be zero, otherwise it faults. On success those PPN bits are replaced by the matching virtual page number bits.
- R9: A load needs R, or X with MXR set. A store needs W. A fetch needs X. Otherwise the access faults.
- R10: A successful leaf that lacks A, or lacks D on a store, is written back by a compare-and-swap carrying the read entry as the compare value and the entry with A set (and D set for a store) as the new value.
- R11: When the compare-and-swap response differs from the entry that was read, the walk restarts from the root and the result follows the entry found then.
- R12: The granted read permission is R, or X with MXR set. Execute is X. Write is granted only when W is set and either the access is a store or D was already set.
- R13: A memory response with the error bit set faults the access.
- R14: req_ready is high only while idle. Each accepted request produces exactly one single-cycle rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_mprv | input | 1 | Machine-mode data override enable |
| req_mpp | input | 2 | Privilege used when the override applies |
| req_sum | input | 1 | Permit supervisor access to user pages |
| req_mxr | input | 1 | Make executable pages readable |
| req_mode | input | 2 | Mode: 0 bare, 1 two-level, 2 three-level |
| req_root | input | 44 | Root table page number |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_r | output | 1 | Read permission |
| rsp_w | output | 1 | Write permission |
| rsp_x | output | 1 | Execute permission |
| rsp_paddr | output | PA_W | Physical address |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | PA_W | Entry address |
| mem_we | output | 1 | Compare-and-swap write when set, read otherwise |
| mem_wdata | output | 64 | New entry value for compare-and-swap |
| mem_cmp | output | 64 | Compare value for compare-and-swap |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_data | input | 64 | Read data, or the old value for compare-and-swap |
| mem_rsp_err | input | 1 | Bus error |

## Verification
The bench builds the walker with PA_W at its default of 56. At that width the full 44-bit page number of a three-level entry reaches the output, so high physical pages and superpage merges in both modes can be observed unchanged. The memory model answers one cycle after each request. It can force a bus error at a chosen entry address and can replace the target entry just before a compare-and-swap, which makes both the restart to a now-invalid entry and the restart to an already-updated entry reachable.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 56
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic [1:0]      req_priv,
  input  logic            req_mprv,
  input  logic [1:0]      req_mpp,
  input  logic            req_sum,
  input  logic            req_mxr,
  input  logic [1:0]      req_mode,
  input  logic [43:0]     req_root,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rsp_r,
  output logic            rsp_w,
  output logic            rsp_x,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_addr,
  output logic            mem_we,
  output logic [63:0]     mem_wdata,
  output logic [63:0]     mem_cmp,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  input  logic            mem_rsp_err
);
  localparam int PPN_W = 44;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_CHK, S_CAS, S_CASW, S_DONE} st_t;

  st_t              st;
  logic [55:0]      va;
  logic [1:0]       acc, upriv, lvl;
  logic             sum, mxr, sv39;
  logic [43:0]      root;
  logic [PA_W-1:0]  base;
  logic [63:0]      pte;

  logic [1:0]  eff_priv;
  logic        canon;
  logic [9:0]  idx;
  logic [4:0]  sh;
  logic [PPN_W-1:0] ppn, mask, pa_ppn;
  logic [63:0] rd, pte_new;
  logic        fetch, store, load, v, r, w, x, u, d;
  logic        priv_bad, acc_bad, leaf_bad, ok_w;

  assign eff_priv = (req_priv == 2'd3 && req_acc != 2'd0 && req_mprv) ? req_mpp : req_priv;
  assign canon    = (&req_vaddr[63:38]) || !(|req_vaddr[63:38]);

  assign fetch = acc == 2'd0;
  assign load  = acc == 2'd1;
  assign store = acc == 2'd2;
  assign {u, x, w, r, v} = pte[4:0];
  assign d = pte[7];

  always_comb begin
    if (sv39)
      case (lvl)
        2'd2:    idx = {1'b0, va[38:30]};
        2'd1:    idx = {1'b0, va[29:21]};
        default: idx = {1'b0, va[20:12]};
      endcase
    else
      idx = (lvl != 2'd0) ? va[31:22] : va[21:12];
  end

  assign sh       = sv39 ? 5'(9 * lvl) : 5'(10 * lvl);
  assign mask     = (44'd1 << sh) - 44'd1;
  assign ppn      = sv39 ? pte[53:10] : {22'd0, pte[31:10]};
  assign pa_ppn   = (ppn & ~mask) | (va[55:12] & mask);
  assign rd       = sv39 ? mem_rsp_data : {32'd0, mem_rsp_data[31:0]};
  assign pte_new  = pte | 64'h40 | (store ? 64'h80 : 64'h0);

  assign priv_bad = u ? (upriv != 2'd0 && (!sum || fetch)) : (upriv != 2'd1);
  assign acc_bad  = load ? !(r || (x && mxr)) : store ? !w : !x;
  assign leaf_bad = (w && !r) || priv_bad || (|(ppn & mask)) || acc_bad;
  assign ok_w     = w && (store || d);

  assign req_ready     = st == S_IDLE;
  assign rsp_valid     = st == S_DONE;
  assign mem_req_valid = st == S_RD || st == S_CAS;
  assign mem_addr      = base + (PA_W'(idx) << (sv39 ? 3 : 2));
  assign mem_we        = st == S_CAS;
  assign mem_wdata     = pte_new;
  assign mem_cmp       = pte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  va <= '0;  acc <= '0;  upriv <= '0;  lvl <= '0;
      sum <= 1'b0;  mxr <= 1'b0;  sv39 <= 1'b0;  root <= '0;  base <= '0;  pte <= '0;
      rsp_fault <= 1'b0;  rsp_r <= 1'b0;  rsp_w <= 1'b0;  rsp_x <= 1'b0;  rsp_paddr <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va    <= req_vaddr[55:0];
          acc   <= req_acc;
          upriv <= eff_priv;
          sum   <= req_sum;
          mxr   <= req_mxr;
          sv39  <= req_mode == 2'd2;
          root  <= req_root;
          base  <= PA_W'({req_root, 12'd0});
          lvl   <= (req_mode == 2'd2) ? 2'd2 : 2'd1;
          {rsp_fault, rsp_r, rsp_w, rsp_x} <= 4'b0;
          rsp_paddr <= '0;
          if (eff_priv == 2'd3 || req_mode == 2'd0) begin
            {rsp_r, rsp_w, rsp_x} <= 3'b111;
            rsp_paddr <= req_vaddr[PA_W-1:0];
            st <= S_DONE;
          end else if (req_mode == 2'd3 || (req_mode == 2'd2 && !canon)) begin
            rsp_fault <= 1'b1;
            st <= S_DONE;
          end else begin
            st <= S_RD;
          end
        end
        S_RD:  if (mem_req_ready) st <= S_RDW;
        S_RDW: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            rsp_fault <= 1'b1;
            st <= S_DONE;
          end else begin
            pte <= rd;
            st <= S_CHK;
          end
        end
        S_CHK: begin
          if (!v) begin
            rsp_fault <= 1'b1;
            st <= S_DONE;
          end else if (!r && !w && !x) begin
            if (lvl == 2'd0) begin
              rsp_fault <= 1'b1;
              st <= S_DONE;
            end else begin
              base <= PA_W'({ppn, 12'd0});
              lvl  <= lvl - 2'd1;
              st   <= S_RD;
            end
          end else if (leaf_bad) begin
            rsp_fault <= 1'b1;
            st <= S_DONE;
          end else if (pte_new != pte) begin
            st <= S_CAS;
          end else begin
            rsp_r <= r || (x && mxr);  rsp_w <= ok_w;  rsp_x <= x;
            rsp_paddr <= PA_W'({pa_ppn, va[11:0]});
            st <= S_DONE;
          end
        end
        S_CAS: if (mem_req_ready) st <= S_CASW;
        S_CASW: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            rsp_fault <= 1'b1;
            st <= S_DONE;
          end else if (rd == pte) begin
            pte <= pte_new;
            rsp_r <= r || (x && mxr);  rsp_w <= ok_w;  rsp_x <= x;
            rsp_paddr <= PA_W'({pa_ppn, va[11:0]});
            st <= S_DONE;
          end else begin
            base <= PA_W'({root, 12'd0});
            lvl  <= sv39 ? 2'd2 : 2'd1;
            st   <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic            rsp_r,
  input logic            rsp_w,
  input logic            rsp_x,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_we,
  input logic [63:0]     mem_wdata,
  input logic [63:0]     mem_cmp
);
  // R14
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R14
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (!rsp_r && !rsp_w && !rsp_x && rsp_paddr == '0));

  // R6
  write_implies_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_w) |-> rsp_r);

  // R10
  cas_only_ad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_we) |-> (((mem_wdata ^ mem_cmp) & ~64'hC0) == 64'h0 && mem_wdata != mem_cmp));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int PA_W = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [63:0]     req_vaddr = '0;
  logic [1:0]      req_acc = '0, req_priv = '0, req_mpp = '0, req_mode = '0;
  logic            req_mprv = 1'b0, req_sum = 1'b0, req_mxr = 1'b0;
  logic [43:0]     req_root = '0;
  logic            rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
  logic [PA_W-1:0] rsp_paddr;
  logic            mem_req_valid, mem_we;
  logic            mem_req_ready = 1'b1;
  logic [PA_W-1:0] mem_addr;
  logic [63:0]     mem_wdata, mem_cmp;
  logic            mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0]     mem_rsp_data = '0;

  pt_walker #(.PA_W(PA_W)) u_pt_walker (.*);

  int checks = 0, failures = 0;

  bit [63:0] mem [bit [55:0]];
  bit [55:0] err_addr = '1;
  bit        intf_on = 1'b0;
  bit [63:0] intf_val = '0;

  always @(posedge clk) begin
    bit [63:0] cur;
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (mem_req_valid) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_err   <= (mem_addr == err_addr);
      cur = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
      if (mem_we) begin
        if (intf_on) begin
          cur = intf_val;
          intf_on = 1'b0;
        end
        mem[mem_addr] = (cur == mem_cmp) ? mem_wdata : cur;
      end
      mem_rsp_data <= cur;
    end
  end

  typedef struct {
    string     tag;
    bit        f, r, w, x;
    bit [55:0] pa;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(bit ok, string req, string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R14", "unexpected response: actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({rsp_fault, rsp_r, rsp_w, rsp_x} == {e.f, e.r, e.w, e.x} && rsp_paddr == e.pa, e.tag,
            $sformatf("actual f%0b r%0b w%0b x%0b pa=%h expected f%0b r%0b w%0b x%0b pa=%h",
                      rsp_fault, rsp_r, rsp_w, rsp_x, rsp_paddr, e.f, e.r, e.w, e.x, e.pa));
      end
    end
  end

  function automatic bit [63:0] mkpte(bit [43:0] ppn, bit [7:0] fl);
    return ({20'd0, ppn} << 10) | {56'd0, fl};
  endfunction

  localparam bit [7:0] V = 8'h01, R = 8'h02, W = 8'h04, X = 8'h08, U = 8'h10, A = 8'h40, D = 8'h80;
  localparam bit [55:0] LEAF39 = 56'h102018;
  localparam bit [63:0] VA39 = 64'h4040_3abc;
  localparam bit [55:0] PA39 = 56'h8000_5abc;

  task automatic go(string tag, bit [1:0] mode, bit [1:0] priv, bit [1:0] acc, bit [63:0] va,
                    bit f, bit r, bit w, bit x, bit [55:0] pa);
    exp_t e;
    e.tag = tag; e.f = f; e.r = r; e.w = w; e.x = x; e.pa = pa;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode = mode; req_priv = priv; req_acc = acc; req_vaddr = va;
    req_root = (mode == 2'd1) ? 44'h200 : 44'h100;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R14", $sformatf("req_ready after accept actual %0b expected 0", req_ready));
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish: actual hung expected done");
    summary();
  end

  initial begin
    mem[56'h100008] = mkpte(44'h101, V);
    mem[56'h101010] = mkpte(44'h102, V);
    mem[56'h200014] = mkpte(44'h201, V);
    mem[56'h20101c] = mkpte(44'h3456, V | R | W | A | D);
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R14",
        $sformatf("reset state actual ready%0b rsp%0b mem%0b expected 1 0 0", req_ready, rsp_valid, mem_req_valid));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 machine and bare bypass
    go("R1 machine bypass", 2'd2, 2'd3, 2'd1, VA39, 0, 1, 1, 1, VA39[55:0]);
    go("R1 bare bypass", 2'd0, 2'd1, 2'd0, 64'h00ab_cdef_1234_5678, 0, 1, 1, 1, 56'hab_cdef_1234_5678);

    // R10 A set on load, write permission withheld while clean (R12)
    mem[LEAF39] = mkpte(44'h80005, V | R | W);
    go("R10 R12 load clean", 2'd2, 2'd1, 2'd1, VA39, 0, 1, 0, 0, PA39);
    chk(mem[LEAF39] == mkpte(44'h80005, V | R | W | A), "R10",
        $sformatf("entry after load actual %h expected %h", mem[LEAF39], mkpte(44'h80005, V | R | W | A)));
    go("R10 R12 store sets D", 2'd2, 2'd1, 2'd2, VA39, 0, 1, 1, 0, PA39);
    chk(mem[LEAF39] == mkpte(44'h80005, V | R | W | A | D), "R10",
        $sformatf("entry after store actual %h expected %h", mem[LEAF39], mkpte(44'h80005, V | R | W | A | D)));
    go("R12 load dirty page", 2'd2, 2'd1, 2'd1, VA39, 0, 1, 1, 0, PA39);

    // R2 override privilege
    req_mprv = 1'b1; req_mpp = 2'd1;
    go("R2 override load", 2'd2, 2'd3, 2'd1, VA39, 0, 1, 1, 0, PA39);
    go("R2 fetch ignores override", 2'd2, 2'd3, 2'd0, VA39, 0, 1, 1, 1, VA39[55:0]);
    req_mpp = 2'd0;
    go("R2 override to user on S page", 2'd2, 2'd3, 2'd1, VA39, 1, 0, 0, 0, '0);
    req_mprv = 1'b0; req_mpp = 2'd0;

    // R3 canonical form
    go("R3 non-canonical", 2'd2, 2'd1, 2'd1, VA39 | 64'h0000_8000_0000_0000, 1, 0, 0, 0, '0);
    go("R3 mode 3", 2'd3, 2'd1, 2'd1, VA39, 1, 0, 0, 0, '0);

    // R5 invalid entry and pointer at the last level
    mem[LEAF39] = 64'h0;
    go("R5 invalid", 2'd2, 2'd1, 2'd1, VA39, 1, 0, 0, 0, '0);
    mem[LEAF39] = mkpte(44'h103, V);
    go("R5 pointer at last level", 2'd2, 2'd1, 2'd1, VA39, 1, 0, 0, 0, '0);

    // R6 reserved encodings
    mem[LEAF39] = mkpte(44'h80005, V | W | A | D);
    go("R6 W only", 2'd2, 2'd1, 2'd2, VA39, 1, 0, 0, 0, '0);
    mem[LEAF39] = mkpte(44'h80005, V | W | X | A | D);
    go("R6 W plus X", 2'd2, 2'd1, 2'd0, VA39, 1, 0, 0, 0, '0);

    // R7 user and supervisor pages
    mem[LEAF39] = mkpte(44'h80005, V | R | U | A);
    go("R7 S load U page no SUM", 2'd2, 2'd1, 2'd1, VA39, 1, 0, 0, 0, '0);
    go("R7 U load U page", 2'd2, 2'd0, 2'd1, VA39, 0, 1, 0, 0, PA39);
    req_sum = 1'b1;
    go("R7 S load U page SUM", 2'd2, 2'd1, 2'd1, VA39, 0, 1, 0, 0, PA39);
    mem[LEAF39] = mkpte(44'h80005, V | X | U | A);
    go("R7 S fetch U page SUM", 2'd2, 2'd1, 2'd0, VA39, 1, 0, 0, 0, '0);
    req_sum = 1'b0;
    mem[LEAF39] = mkpte(44'h80005, V | R | A);
    go("R7 U load S page", 2'd2, 2'd0, 2'd1, VA39, 1, 0, 0, 0, '0);

    // R9 access rights, R12 MXR read grant
    mem[LEAF39] = mkpte(44'h80005, V | X | A);
    go("R9 load X page no MXR", 2'd2, 2'd1, 2'd1, VA39, 1, 0, 0, 0, '0);
    req_mxr = 1'b1;
    go("R9 R12 load X page MXR", 2'd2, 2'd1, 2'd1, VA39, 0, 1, 0, 1, PA39);
    req_mxr = 1'b0;
    mem[LEAF39] = mkpte(44'h80005, V | R | A);
    go("R9 store R page", 2'd2, 2'd1, 2'd2, VA39, 1, 0, 0, 0, '0);
    go("R9 fetch R page", 2'd2, 2'd1, 2'd0, VA39, 1, 0, 0, 0, '0);

    // R8 superpage merge and misalignment
    mem[56'h101010] = mkpte(44'h80200, V | R | W | A | D);
    go("R8 aligned megapage", 2'd2, 2'd1, 2'd1, VA39, 0, 1, 1, 0, 56'h8020_3abc);
    mem[56'h101010] = mkpte(44'h80201, V | R | W | A | D);
    go("R8 misaligned megapage", 2'd2, 2'd1, 2'd1, VA39, 1, 0, 0, 0, '0);
    mem[56'h101010] = mkpte(44'h102, V);

    // R13 bus error
    mem[LEAF39] = mkpte(44'h80005, V | R | A);
    err_addr = LEAF39;
    go("R13 bus error", 2'd2, 2'd1, 2'd1, VA39, 1, 0, 0, 0, '0);
    err_addr = '1;

    // R11 interference during compare-and-swap
    mem[LEAF39] = mkpte(44'h80005, V | R | W);
    intf_on = 1'b1; intf_val = 64'h0;
    go("R11 restart finds invalid", 2'd2, 2'd1, 2'd1, VA39, 1, 0, 0, 0, '0);
    chk(mem[LEAF39] == 64'h0, "R11", $sformatf("entry after failed swap actual %h expected 0", mem[LEAF39]));
    mem[LEAF39] = mkpte(44'h80005, V | R | W);
    intf_on = 1'b1; intf_val = mkpte(44'h80007, V | R | W | A);
    go("R11 restart finds updated", 2'd2, 2'd1, 2'd1, VA39, 0, 1, 0, 0, 56'h8000_7abc);
    chk(mem[LEAF39] == mkpte(44'h80007, V | R | W | A), "R11",
        $sformatf("entry after restart actual %h expected %h", mem[LEAF39], mkpte(44'h80007, V | R | W | A)));

    // R4 two-level walk, upper address bits ignored, and its superpage (R8)
    go("R4 two-level page", 2'd1, 2'd1, 2'd2, 64'hdead_0000_0140_7123, 0, 1, 1, 0, 56'h345_6123);
    mem[56'h200014] = mkpte(44'h400, V | R | X | A);
    go("R4 R8 two-level superpage", 2'd1, 2'd1, 2'd1, 64'h0140_7123, 0, 1, 0, 1, 56'h40_7123);
    mem[56'h200014] = mkpte(44'h401, V | R | X | A);
    go("R8 two-level misaligned", 2'd1, 2'd1, 2'd1, 64'h0140_7123, 1, 0, 0, 0, '0);

    summary();
  end
endmodule